// File: doc/BRIEF.md
# Dual-Path Transition-Timeout Selector

This block decides which of two recovered data paths drives a channel output. The fast path delivers only edge events: a one-cycle rise pulse for each 0-to-1 transition of the data and a one-cycle fall pulse for each 1-to-0 transition. From these pulses the block rebuilds the data level. The slow path delivers a level that has already been demodulated from a pulse-width-modulated carrier and low-pass filtered upstream. The fast path covers signalling from roughly 100 kbps up to 25 Mbps. The slow path covers DC up to roughly 100 kbps.

A gap timer counts clock cycles since the last edge event on the fast path. When the gap grows beyond a parameterised limit, the data is too slow for the edge path to be trusted, so the output multiplexer hands the output to the slow path. Any new edge event clears the timer and returns the output to the fast path at once. A select flag is brought out for observation. A rise and a fall in the same cycle is reported as a protocol error. The rebuilt level does not change on such a cycle.

The limit is set in clock cycles and is meant to sit just under the transition interval of a 100 kbps stream. At a 200 MHz clock, 10 µs is 2000 cycles.

Top module: `dual_path_selector`

## Requirements
- R1: While rst_ni is low and after its release, sel_lr_o is 1, proto_err_o is 0, and data_o equals lr_level_i.
- R2: A cycle where rise_i is 1 and fall_i is 0 makes data_o 1 and sel_lr_o 0 from the next clock edge on.
- R3: A cycle where fall_i is 1 and rise_i is 0 makes data_o 0 and sel_lr_o 0 from the next clock edge on.
- R4: A cycle where rise_i and fall_i are both 1 leaves the rebuilt level unchanged and clears sel_lr_o. It also raises proto_err_o for exactly the following cycle.
- R5: proto_err_o is 0 in the cycle after any sampled cycle that does not have both rise_i and fall_i high.
- R6: After the last edge event, sel_lr_o stays 0 while up to LIMIT_CYC idle cycles have been sampled. It becomes 1 on the clock edge that samples idle cycle LIMIT_CYC+1, and stays 1 until the next event.
- R7: While sel_lr_o is 1, data_o follows lr_level_i in the same cycle. While sel_lr_o is 0, lr_level_i has no effect on data_o.
- R8: An edge event that arrives while sel_lr_o is 1 returns sel_lr_o to 0 at the next clock edge. data_o then shows the level that edge encodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rise_i | input | 1 | Fast-path event: data went 0 to 1 |
| fall_i | input | 1 | Fast-path event: data went 1 to 0 |
| lr_level_i | input | 1 | Demodulated slow-path level |
| data_o | output | 1 | Selected channel output |
| sel_lr_o | output | 1 | 1 when the slow path drives data_o |
| proto_err_o | output | 1 | One-cycle flag for a simultaneous rise and fall |

## Verification
Two functions can fall in the same cycle: an edge event can arrive on the very clock where the gap timer would expire, and a rise and a fall can be sampled together. The bench places single events exactly LIMIT_CYC and LIMIT_CYC+1 idle cycles after the previous one. It also issues conflicting pulses both in slow-path mode and in fast-path mode. Random event streams with sparse edges then drive the timer across its limit many times. Every cycle is judged against a bench model built from the requirements, which covers the level, the selection, the error flag and the same-cycle effect of lr_level_i.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic {
    SRC_HR = 1'b0,
    SRC_LR = 1'b1
  } src_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'b00,
    EV_RISE  = 2'b01,
    EV_FALL  = 2'b10,
    EV_CLASH = 2'b11
  } ev_e;

  function automatic ev_e classify(input logic rise, input logic fall);
    return ev_e'({fall, rise});
  endfunction
endpackage

// File: rtl/dps_edge_decoder.sv
module dps_edge_decoder
  import dps_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  output logic evt_o,
  output logic level_o,
  output logic err_o
);
  ev_e  ev;
  logic level_q, err_q;

  assign ev    = classify(rise_i, fall_i);
  assign evt_o = (ev != EV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (ev == EV_CLASH);
      case (ev)
        EV_RISE: level_q <= 1'b1;
        EV_FALL: level_q <= 1'b0;
        default: level_q <= level_q; // clash or idle: hold
      endcase
    end
  end

  assign level_o = level_q;
  assign err_o   = err_q;

  a_r2_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !fall_i) |=> level_o);
  a_r3_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !rise_i) |=> !level_o);
  a_r4_clash_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && fall_i) |=> ($stable(level_o) && err_o));
  a_r5_no_spurious_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && fall_i) |=> !err_o);
endmodule

// File: rtl/dps_gap_timer.sv
module dps_gap_timer
  import dps_pkg::*;
#(
  parameter int unsigned LIMIT_CYC = 2000,
  localparam int unsigned CNT_W    = $clog2(LIMIT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output src_e src_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LIMIT_CYC);

  logic [CNT_W-1:0] cnt_q;
  src_e             src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      src_q <= SRC_LR;
    end else if (evt_i) begin
      cnt_q <= '0;
      src_q <= SRC_HR;
    end else if (cnt_q == LIMIT) begin
      // gap has exceeded the limit: saturate and hand over
      src_q <= SRC_LR;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign src_o = src_q;

  a_r8_event_returns_hr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (src_o == SRC_HR));
  a_r6_switch_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == SRC_HR) ##1 (src_o == SRC_LR) |-> ($past(cnt_q) == LIMIT && !$past(evt_i)));
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/dps_out_mux.sv
module dps_out_mux
  import dps_pkg::*;
(
  input  src_e src_i,
  input  logic hr_level_i,
  input  logic lr_level_i,
  output logic data_o
);
  always_comb begin
    unique case (src_i)
      SRC_LR:  data_o = lr_level_i;
      default: data_o = hr_level_i;
    endcase
  end
endmodule

// File: rtl/dual_path_selector.sv
module dual_path_selector
  import dps_pkg::*;
#(
  parameter int unsigned LIMIT_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic lr_level_i,
  output logic data_o,
  output logic sel_lr_o,
  output logic proto_err_o
);
  logic evt, hr_level;
  src_e src;

  dps_edge_decoder u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise_i),
    .fall_i  (fall_i),
    .evt_o   (evt),
    .level_o (hr_level),
    .err_o   (proto_err_o)
  );

  dps_gap_timer #(.LIMIT_CYC(LIMIT_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .src_o  (src)
  );

  dps_out_mux u_mux (
    .src_i      (src),
    .hr_level_i (hr_level),
    .lr_level_i (lr_level_i),
    .data_o     (data_o)
  );

  assign sel_lr_o = (src == SRC_LR);

  a_r2_rise_to_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !fall_i) |=> (data_o && !sel_lr_o));
  a_r3_fall_to_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !rise_i) |=> (!data_o && !sel_lr_o));
  a_r4_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> (!proto_err_o || $past(rise_i && fall_i)));
endmodule

// File: tb/sim_dual_path_selector.sv
`timescale 1ns/1ps
module sim_dual_path_selector;
  localparam int LIM = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rise = 1'b0, fall = 1'b0, lr = 1'b1;
  logic data, sel_lr, perr;

  int total = 0, bad = 0;
  bit m_level, m_sel, m_err;
  int m_idle;

  always #2.5 clk = ~clk;

  dual_path_selector #(.LIMIT_CYC(LIM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rise_i(rise), .fall_i(fall),
    .lr_level_i(lr), .data_o(data), .sel_lr_o(sel_lr), .proto_err_o(perr)
  );

  function automatic bit exp_data(bit sel, bit lvl, bit lrv);
    return sel ? lrv : lvl;
  endfunction

  task automatic chk(string req, logic got, bit exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk(req, data, exp_data(m_sel, m_level, lr));
    chk(req, sel_lr, m_sel);
    chk(req, perr, m_err);
  endtask

  // one sampled cycle: drive, advance model at posedge, check at negedge
  task automatic cyc(bit r, bit f, bit l, string req);
    rise = r; fall = f; lr = l;
    @(posedge clk);
    m_err = r && f;
    if (r || f) begin
      m_idle = 0;
      m_sel  = 1'b0;
      if (r && !f) m_level = 1'b1;
      if (f && !r) m_level = 1'b0;
    end else begin
      if (m_idle <= LIM) m_idle++;
      if (m_idle > LIM) m_sel = 1'b1;
    end
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(5.0 * 190000);
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_level = 0; m_sel = 1; m_err = 0; m_idle = LIM + 1;
    repeat (3) @(negedge clk);
    // R1 during reset: slow path drives the output
    chk("R1 sel", sel_lr, 1'b1);
    chk("R1 err", perr, 1'b0);
    chk("R1 data", data, 1'b1);
    lr = 1'b0; #1;
    chk("R1 data follows lr", data, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 1, "R1 after release");

    // R2 / R8: rise while in slow-path mode, with lr opposing
    cyc(1, 0, 0, "R8 rise from lr mode");
    chk("R2 data high", data, 1'b1);
    // R7: lr toggling has no effect in fast-path mode
    lr = 1'b0; #1; chk("R7 lr ignored", data, 1'b1);
    lr = 1'b1; #1; chk("R7 lr ignored", data, 1'b1);
    // R3
    cyc(0, 1, 1, "R3 fall");
    chk("R3 data low", data, 1'b0);
    // R4 clash: level held at 0, error one cycle
    cyc(1, 1, 1, "R4 clash");
    chk("R4 err raised", perr, 1'b1);
    chk("R4 level held", data, 1'b0);
    cyc(0, 0, 1, "R5 err clears");
    chk("R5 err low", perr, 1'b0);

    // R6 boundary: event after exactly LIM idle cycles keeps fast path
    cyc(1, 0, 0, "R6 arm");
    for (int i = 0; i < LIM; i++) cyc(0, 0, 0, "R6 within limit");
    chk("R6 still hr at limit", sel_lr, 1'b0);
    cyc(0, 1, 1, "R6 event at limit");
    chk("R6 stays hr", sel_lr, 1'b0);
    // now LIM+1 idle cycles
    for (int i = 0; i < LIM; i++) cyc(0, 0, 1, "R6 idle");
    chk("R6 hr before expiry", sel_lr, 1'b0);
    cyc(0, 0, 1, "R6 expiry");
    chk("R6 lr after expiry", sel_lr, 1'b1);
    chk("R7 lr drives", data, 1'b1);
    lr = 1'b0; #1; chk("R7 same-cycle follow", data, 1'b0);
    @(negedge clk);
    // R4 clash in lr mode: back to fast path, level held at 0
    cyc(1, 1, 1, "R4 clash from lr");
    chk("R4 sel hr", sel_lr, 1'b0);
    chk("R4 data held", data, 1'b0);

    // random sparse traffic
    for (int n = 0; n < 6000; n++) begin
      int p;
      bit r, f;
      p = $urandom_range(0, 99);
      r = (p < 2) || (p == 99);
      f = ((p >= 2) && (p < 4)) || (p == 99);
      if (n % 500 < 200) begin r = (p < 20) || (p == 98); f = (p >= 20 && p < 40) || (p == 98); end
      cyc(r, f, 1'($urandom_range(0, 1)), "R2/R3/R4/R5/R6/R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule